// File: doc/BRIEF.md
# Pointer-Addressed Register File with Data-Address Generator

This block holds the 32 eight-bit working registers of a small processor, together with the logic that turns a pointer held in those registers into a data-space address for a load or a store. Two combinational read ports and one write port serve the datapath. Three 16-bit pointers, X, Y and Z, are each made of two adjacent upper registers. A load or store names a pointer and an addressing mode. The generator forms the effective address and, in the auto-modify modes, writes the updated pointer back into the file. It also classifies the address into one of three regions and steers the access to the register file itself, to an I/O strobe pair or to an SRAM strobe pair. A program-memory load fetches a byte at the address held in Z and always places it in register 0.

Each access is run by a two-state sequencer. In ST_IDLE the block takes a request when `acc_start` is high. It latches the address, the region, the data register and any pointer update, then moves to ST_XFER (transition "accept"). ST_XFER lasts exactly one cycle. During that cycle the block drives the address and the one strobe that matches the region. At the closing edge it writes the load result and the pointer update, then returns to ST_IDLE unconditionally (transition "complete"). `acc_start` is ignored in ST_XFER.

Top module: `ptr_regfile_agu`

## Requirements
- R1: After reset all 32 registers read 0x00, `busy` is low and every memory strobe is low.
- R2: `rd_a_data` and `rd_b_data` show the register chosen by their select input combinationally. A register written through `wr_en`/`wr_sel`/`wr_data` shows the new value after that clock edge.
- R3: An effective address below 0x20 selects the register with that index. Addresses 0x20 to 0x5F go to I/O, with `io_addr` equal to the address minus 0x20. Any address of 0x60 or above goes to SRAM on the full `mem_addr`. In ST_XFER exactly one of `io_re`, `io_we`, `sram_re`, `sram_we`, `pm_re` is high, or none for a register-region access.
- R4: `acc_ptr` code 0 selects X = {r27,r26}, code 1 selects Y = {r29,r28}, and codes 2 and 3 select Z = {r31,r30}. The low byte is in the even register. `acc_kind` 0 is a load into `acc_reg`, 1 is a store of `acc_reg`, and 2 or 3 is a program-memory load. `acc_mode` 0 is plain indirect.
- R5: `acc_mode` 1 (post-increment) uses the pointer as the address, and the pointer then holds its value plus 1, modulo 2^16.
- R6: `acc_mode` 2 (pre-decrement) uses the pointer minus 1, modulo 2^16, as the address, and the pointer keeps that value.
- R7: `acc_mode` 3 (displacement) uses Y or Z plus the unsigned 6-bit `acc_disp` and leaves the pointer unchanged. For X the displacement is ignored and the access behaves as plain indirect.
- R8: A program-memory load drives `pm_re` with `mem_addr` equal to Z, writes `pm_rdata` into r0, and leaves every pointer unchanged whatever `acc_ptr` and `acc_mode` hold.
- R9: When writes meet on one register at the same edge, the data written by the access (load result, or a store into the register region) wins over the pointer write-back, and the pointer write-back wins over the external write port.
- R10: An accepted request holds `busy` high for exactly one cycle, the ST_XFER cycle. A request raised during that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 5 | Read port A register select |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Read port B register select |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | External write enable |
| wr_sel | input | 5 | External write register select |
| wr_data | input | 8 | External write data |
| acc_start | input | 1 | Request an access (taken in ST_IDLE) |
| acc_kind | input | 2 | 0 load, 1 store, 2/3 program-memory load |
| acc_ptr | input | 2 | 0 X, 1 Y, 2/3 Z |
| acc_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| acc_disp | input | 6 | Unsigned displacement |
| acc_reg | input | 5 | Load destination or store source register |
| busy | output | 1 | High in the ST_XFER cycle |
| mem_addr | output | 16 | Effective address during ST_XFER |
| mem_wdata | output | 8 | Store data during ST_XFER |
| io_re | output | 1 | I/O read strobe |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 6 | I/O location (address minus 0x20) |
| io_rdata | input | 8 | I/O read data, sampled in ST_XFER |
| sram_re | output | 1 | SRAM read strobe |
| sram_we | output | 1 | SRAM write strobe |
| sram_rdata | input | 8 | SRAM read data, sampled in ST_XFER |
| pm_re | output | 1 | Program-memory read strobe |
| pm_rdata | input | 8 | Program-memory byte, sampled in ST_XFER |

## Verification
The assertions assume that the read data inputs are valid within the ST_XFER cycle in which the strobe is high. They also assume that Z does not change during the accept cycle other than through the block, so the program-memory address matches Z as it was when the request was taken. The bench drives every input on the falling edge and gives the read data before each request. It keeps the external write port quiet in accept cycles and uses it only inside ST_XFER, where its priority is defined. Pointer values are drawn mostly below 0x0100 so that all three regions and the wrap at zero occur often.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        RG_FILE = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ptr_gpr_file.sv
module ptr_gpr_file #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    parameter int AW   = 2 * DW,
    parameter int SW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SW-1:0]        rsel_a,
    output logic [DW-1:0]        rdata_a,
    input  logic [SW-1:0]        rsel_b,
    output logic [DW-1:0]        rdata_b,
    input  logic [SW-1:0]        rsel_c,
    output logic [DW-1:0]        rdata_c,
    input  logic                 ext_we,
    input  logic [SW-1:0]        ext_sel,
    input  logic [DW-1:0]        ext_data,
    input  logic                 pair_we,
    input  logic [1:0]           pair_idx,
    input  logic [AW-1:0]        pair_val,
    input  logic                 mem_we,
    input  logic [SW-1:0]        mem_sel,
    input  logic [DW-1:0]        mem_data,
    output logic [2:0][AW-1:0]   ptrs
);
    localparam int PAIR_BASE = NREG - 6;

    logic [DW-1:0] regs [NREG];
    logic [SW-1:0] pair_lo;
    logic [SW-1:0] pair_hi;

    assign pair_lo = SW'(PAIR_BASE) + SW'({pair_idx, 1'b0});
    assign pair_hi = pair_lo | SW'(1);

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];
    assign rdata_c = regs[rsel_c];

    // Access data first, then pointer update, then the external port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (mem_we && mem_sel == SW'(i))
                    regs[i] <= mem_data;
                else if (pair_we && pair_lo == SW'(i))
                    regs[i] <= pair_val[DW-1:0];
                else if (pair_we && pair_hi == SW'(i))
                    regs[i] <= pair_val[AW-1:DW];
                else if (ext_we && ext_sel == SW'(i))
                    regs[i] <= ext_data;
            end
        end
    end

    for (genvar p = 0; p < 3; p++) begin : g_ptr
        assign ptrs[p] = {regs[PAIR_BASE + 2*p + 1], regs[PAIR_BASE + 2*p]};
    end

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import ptr_agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int QW   = 6,
    parameter int NREG = 32,
    parameter int NIO  = 64
) (
    input  logic [2:0][AW-1:0] ptrs,
    input  logic [1:0]         ptr_sel,
    input  addr_mode_e         mode,
    input  logic [QW-1:0]      disp,
    input  logic               prog,
    output logic [AW-1:0]      ea,
    output logic               wb_en,
    output logic [1:0]         wb_pair,
    output logic [AW-1:0]      wb_val,
    output region_e            region
);
    localparam logic [AW-1:0] IO_LO   = AW'(NREG);
    localparam logic [AW-1:0] SRAM_LO = AW'(NREG + NIO);

    logic [AW-1:0] base;

    always_comb begin
        wb_pair = (ptr_sel == 2'd0) ? 2'd0 : (ptr_sel == 2'd1) ? 2'd1 : 2'd2;
        base    = ptrs[wb_pair];
        ea      = base;
        wb_val  = base;
        wb_en   = 1'b0;
        if (prog) begin
            ea = ptrs[2];
        end else begin
            unique case (mode)
                AM_PLAIN: ;
                AM_POSTINC: begin
                    wb_val = base + AW'(1);
                    wb_en  = 1'b1;
                end
                AM_PREDEC: begin
                    wb_val = base - AW'(1);
                    ea     = wb_val;
                    wb_en  = 1'b1;
                end
                AM_DISP: begin
                    if (wb_pair != 2'd0) ea = base + AW'(disp);
                end
            endcase
        end
    end

    always_comb begin
        if (ea < IO_LO)        region = RG_FILE;
        else if (ea < SRAM_LO) region = RG_IO;
        else                   region = RG_SRAM;
    end

endmodule

// File: rtl/ptr_regfile_agu.sv
module ptr_regfile_agu
    import ptr_agu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 32,
    parameter int AW   = 16,
    parameter int QW   = 6,
    parameter int NIO  = 64,
    localparam int SW  = $clog2(NREG),
    localparam int IOW = $clog2(NIO)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd_a_sel,
    output logic [DW-1:0]   rd_a_data,
    input  logic [SW-1:0]   rd_b_sel,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            acc_start,
    input  logic [1:0]      acc_kind,
    input  logic [1:0]      acc_ptr,
    input  logic [1:0]      acc_mode,
    input  logic [QW-1:0]   acc_disp,
    input  logic [SW-1:0]   acc_reg,
    output logic            busy,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            io_re,
    output logic            io_we,
    output logic [IOW-1:0]  io_addr,
    input  logic [DW-1:0]   io_rdata,
    output logic            sram_re,
    output logic            sram_we,
    input  logic [DW-1:0]   sram_rdata,
    output logic            pm_re,
    input  logic [DW-1:0]   pm_rdata
);
    seq_state_e state_q, state_d;

    logic [2:0][AW-1:0] ptrs;
    logic [AW-1:0]      ptr_z;
    logic [AW-1:0]      ea_c, wb_val_c;
    logic               wb_en_c;
    logic [1:0]         wb_pair_c;
    region_e            region_c;
    logic               prog_c;

    logic               prog_q, store_q, wb_en_q;
    logic [SW-1:0]      reg_q;
    logic [AW-1:0]      ea_q, wb_val_q;
    logic [1:0]         wb_pair_q;
    region_e            region_q;

    logic [SW-1:0]      rsel_c;
    logic [DW-1:0]      rdata_c;
    logic               rf_we;
    logic [SW-1:0]      rf_sel;
    logic [DW-1:0]      rf_data;
    logic               accept;

    assign prog_c = acc_kind[1];
    assign accept = (state_q == ST_IDLE) && acc_start;
    assign ptr_z  = ptrs[2];
    assign rsel_c = store_q ? reg_q : ea_q[SW-1:0];

    ptr_addr_gen #(.AW(AW), .QW(QW), .NREG(NREG), .NIO(NIO)) u_agu (
        .ptrs    (ptrs),
        .ptr_sel (acc_ptr),
        .mode    (addr_mode_e'(acc_mode)),
        .disp    (acc_disp),
        .prog    (prog_c),
        .ea      (ea_c),
        .wb_en   (wb_en_c),
        .wb_pair (wb_pair_c),
        .wb_val  (wb_val_c),
        .region  (region_c)
    );

    ptr_gpr_file #(.DW(DW), .NREG(NREG), .AW(AW)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .rsel_a   (rd_a_sel),
        .rdata_a  (rd_a_data),
        .rsel_b   (rd_b_sel),
        .rdata_b  (rd_b_data),
        .rsel_c   (rsel_c),
        .rdata_c  (rdata_c),
        .ext_we   (wr_en),
        .ext_sel  (wr_sel),
        .ext_data (wr_data),
        .pair_we  (wb_en_q && state_q == ST_XFER),
        .pair_idx (wb_pair_q),
        .pair_val (wb_val_q),
        .mem_we   (rf_we),
        .mem_sel  (rf_sel),
        .mem_data (rf_data),
        .ptrs     (ptrs)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = acc_start ? ST_XFER : ST_IDLE;
            ST_XFER: state_d = ST_IDLE;
        endcase
    end

    // Request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q    <= 1'b0;
            store_q   <= 1'b0;
            wb_en_q   <= 1'b0;
            reg_q     <= '0;
            ea_q      <= '0;
            wb_val_q  <= '0;
            wb_pair_q <= '0;
            region_q  <= RG_FILE;
        end else if (accept) begin
            prog_q    <= prog_c;
            store_q   <= (acc_kind == 2'd1);
            wb_en_q   <= wb_en_c && !prog_c;
            reg_q     <= acc_reg;
            ea_q      <= ea_c;
            wb_val_q  <= wb_val_c;
            wb_pair_q <= wb_pair_c;
            region_q  <= region_c;
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        io_re     = 1'b0;
        io_we     = 1'b0;
        io_addr   = '0;
        sram_re   = 1'b0;
        sram_we   = 1'b0;
        pm_re     = 1'b0;
        rf_we     = 1'b0;
        rf_sel    = '0;
        rf_data   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy     = 1'b1;
                mem_addr = ea_q;
                io_addr  = IOW'(ea_q - AW'(NREG));
                if (prog_q) begin
                    pm_re   = 1'b1;
                    rf_we   = 1'b1;
                    rf_data = pm_rdata;
                end else if (store_q) begin
                    mem_wdata = rdata_c;
                    unique case (region_q)
                        RG_FILE: begin
                            rf_we   = 1'b1;
                            rf_sel  = ea_q[SW-1:0];
                            rf_data = rdata_c;
                        end
                        RG_IO:   io_we   = 1'b1;
                        default: sram_we = 1'b1;
                    endcase
                end else begin
                    rf_we  = 1'b1;
                    rf_sel = reg_q;
                    unique case (region_q)
                        RG_FILE: rf_data = rdata_c;
                        RG_IO: begin
                            io_re   = 1'b1;
                            rf_data = io_rdata;
                        end
                        default: begin
                            sram_re = 1'b1;
                            rf_data = sram_rdata;
                        end
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/ptr_agu_checker.sv
module ptr_agu_checker #(
    parameter int AW   = 16,
    parameter int NREG = 32,
    parameter int NIO  = 64,
    parameter int IOW  = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           acc_start,
    input logic           io_re,
    input logic           io_we,
    input logic           sram_re,
    input logic           sram_we,
    input logic           pm_re,
    input logic [AW-1:0]  mem_addr,
    input logic [IOW-1:0] io_addr,
    input logic [AW-1:0]  z_now
);
    localparam logic [AW-1:0] IO_LO   = AW'(NREG);
    localparam logic [AW-1:0] SRAM_LO = AW'(NREG + NIO);

    p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_re, io_we, sram_re, sram_we, pm_re}));

    p_io_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_re || io_we) |-> (mem_addr >= IO_LO && mem_addr < SRAM_LO
                              && AW'(io_addr) + IO_LO == mem_addr));

    p_sram_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_re || sram_we) |-> mem_addr >= SRAM_LO);

    p_prog_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_re |-> mem_addr == $past(z_now));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(io_re || io_we || sram_re || sram_we || pm_re));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy) |=> busy);

endmodule

bind ptr_regfile_agu ptr_agu_checker #(
    .AW(AW), .NREG(NREG), .NIO(NIO), .IOW(IOW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .acc_start (acc_start),
    .io_re     (io_re),
    .io_we     (io_we),
    .sram_re   (sram_re),
    .sram_we   (sram_we),
    .pm_re     (pm_re),
    .mem_addr  (mem_addr),
    .io_addr   (io_addr),
    .z_now     (ptr_z)
);

// File: tb/test_ptr_regfile_agu.sv
module test_ptr_regfile_agu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0, acc_reg = '0;
    logic [7:0] rd_a_data, rd_b_data, wr_data = '0;
    logic       wr_en = 1'b0, acc_start = 1'b0;
    logic [1:0] acc_kind = '0, acc_ptr = '0, acc_mode = '0;
    logic [5:0] acc_disp = '0;
    logic       busy, io_re, io_we, sram_re, sram_we, pm_re;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, io_rdata = '0, sram_rdata = '0, pm_rdata = '0;
    logic [5:0] io_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [7:0] m [32];

    always #5ns clk = ~clk;

    ptr_regfile_agu i_ptr_regfile_agu (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_start(acc_start), .acc_kind(acc_kind), .acc_ptr(acc_ptr),
        .acc_mode(acc_mode), .acc_disp(acc_disp), .acc_reg(acc_reg),
        .busy(busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .io_re(io_re), .io_we(io_we), .io_addr(io_addr), .io_rdata(io_rdata),
        .sram_re(sram_re), .sram_we(sram_we), .sram_rdata(sram_rdata),
        .pm_re(pm_re), .pm_rdata(pm_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_of(input logic [1:0] sel);
        int b = (sel == 2'd0) ? 26 : (sel == 2'd1) ? 28 : 30;
        return {m[b+1], m[b]};
    endfunction

    // 0 file, 1 I/O, 2 SRAM
    function automatic int region_of(input logic [15:0] a);
        if (a < 16'h0020) return 0;
        if (a < 16'h0060) return 1;
        return 2;
    endfunction

    task automatic check_file(input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_a_sel = 5'(i);
            rd_b_sel = 5'(i + 16);
            #1;
            chk(tag, {24'd0, rd_a_data}, {24'd0, m[i]});
            chk(tag, {24'd0, rd_b_data}, {24'd0, m[i+16]});
        end
    endtask

    task automatic set_reg(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m[sel] = d;
    endtask

    task automatic set_ptr(input logic [1:0] sel, input logic [15:0] v);
        int b = (sel == 2'd0) ? 26 : (sel == 2'd1) ? 28 : 30;
        set_reg(b, v[7:0]);
        set_reg(b + 1, v[15:8]);
    endtask

    task automatic access(input string tag, input logic [1:0] kind, input logic [1:0] psel,
                          input logic [1:0] mode, input logic [5:0] q, input logic [4:0] r,
                          input bit ext, input logic [4:0] esel, input logic [7:0] edata,
                          input bit hold);
        logic [15:0] p, ea, wbv;
        bit wb;
        int rg, base;
        logic [4:0] strb;
        logic [7:0] ld;
        @(negedge clk);
        acc_start = 1'b1; acc_kind = kind; acc_ptr = psel; acc_mode = mode;
        acc_disp = q; acc_reg = r;
        io_rdata = 8'($urandom); sram_rdata = 8'($urandom); pm_rdata = 8'($urandom);
        p = ptr_of(psel); ea = p; wbv = p; wb = 0;
        base = (psel == 2'd0) ? 26 : (psel == 2'd1) ? 28 : 30;
        if (kind[1]) ea = ptr_of(2'd2);
        else case (mode)
            2'd1: begin wbv = p + 16'd1; wb = 1; end
            2'd2: begin wbv = p - 16'd1; ea = wbv; wb = 1; end
            2'd3: if (psel != 2'd0) ea = p + {10'd0, q};
            default: ;
        endcase
        rg = region_of(ea);
        if (kind[1])            strb = 5'b00001;
        else if (rg == 0)       strb = 5'b00000;
        else if (kind == 2'd1)  strb = (rg == 1) ? 5'b01000 : 5'b00010;
        else                    strb = (rg == 1) ? 5'b10000 : 5'b00100;
        @(negedge clk);
        if (hold) begin
            acc_kind = 2'd0; acc_ptr = 2'd0; acc_mode = 2'd1; acc_reg = 5'd1;
        end else acc_start = 1'b0;
        wr_en = ext; wr_sel = esel; wr_data = edata;
        chk({tag, " busy"}, {31'd0, busy}, 32'd1);
        chk({tag, " addr"}, {16'd0, mem_addr}, {16'd0, ea});
        chk({tag, " strobes"}, {27'd0, io_re, io_we, sram_re, sram_we, pm_re}, {27'd0, strb});
        if (rg == 1 && !kind[1]) chk({tag, " io_addr"}, {26'd0, io_addr}, {16'd0, ea - 16'h20});
        if (kind == 2'd1) chk({tag, " wdata"}, {24'd0, mem_wdata}, {24'd0, m[r]});
        // model update: external, then pointer, then access data (R9)
        ld = kind[1] ? pm_rdata : (rg == 0) ? m[ea[4:0]] : (rg == 1) ? io_rdata : sram_rdata;
        if (kind == 2'd1) ld = m[r];
        if (ext) m[esel] = edata;
        if (wb && !kind[1]) begin m[base] = wbv[7:0]; m[base+1] = wbv[15:8]; end
        if (kind[1])                  m[0] = ld;
        else if (kind == 2'd0)        m[r] = ld;
        else if (rg == 0)             m[ea[4:0]] = ld;
        @(negedge clk);
        acc_start = 1'b0; wr_en = 1'b0;
        chk({tag, " done"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A61));
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 strobes", {27'd0, io_re, io_we, sram_re, sram_we, pm_re}, 32'd0);
        rst_n = 1'b1;
        check_file("R1 reset value");

        // R2 write port and both read ports
        set_reg(5, 8'hA5);
        set_reg(17, 8'h3C);
        check_file("R2 write/read");

        // R4/R5/R9: X = 0x001A, load r26 via X+ -> load wins on r26, pointer wins on r27 over ext
        set_ptr(2'd0, 16'h001A);
        access("R9 load beats pointer", 2'd0, 2'd0, 2'd1, 6'd0, 5'd26, 1, 5'd27, 8'hEE, 0);
        check_file("R9 priority");
        // R9: store into register region over pointer write-back
        set_ptr(2'd0, 16'h001B);
        access("R9 store beats pointer", 2'd1, 2'd0, 2'd1, 6'd0, 5'd5, 0, 5'd0, 8'h00, 0);
        check_file("R9 store priority");
        // R6 pre-decrement wrap from zero into SRAM
        set_ptr(2'd1, 16'h0000);
        access("R6 predec wrap", 2'd0, 2'd1, 2'd2, 6'd0, 5'd3, 0, 5'd0, 8'h00, 0);
        check_file("R6 pointer");
        // R7 displacement ignored for X, used for Z
        set_ptr(2'd0, 16'h0030);
        access("R7 X disp ignored", 2'd0, 2'd0, 2'd3, 6'd5, 5'd2, 0, 5'd0, 8'h00, 0);
        set_ptr(2'd2, 16'h0021);
        access("R7 Z+63", 2'd1, 2'd2, 2'd3, 6'd63, 5'd17, 0, 5'd0, 8'h00, 0);
        check_file("R7 pointers");
        // R3 I/O boundary 0x5F and SRAM 0x60
        set_ptr(2'd1, 16'h005F);
        access("R3 io top", 2'd0, 2'd1, 2'd1, 6'd0, 5'd4, 0, 5'd0, 8'h00, 0);
        access("R3 sram low", 2'd1, 2'd1, 2'd0, 6'd0, 5'd4, 0, 5'd0, 8'h00, 0);
        // R8 program-memory load ignores pointer/mode
        access("R8 prog load", 2'd2, 2'd0, 2'd1, 6'd9, 5'd9, 0, 5'd0, 8'h00, 0);
        check_file("R8 r0 and pointers");
        // R10 request during ST_XFER ignored
        access("R10 held start", 2'd0, 2'd1, 2'd0, 6'd0, 5'd6, 0, 5'd0, 8'h00, 1);
        chk("R10 no second accept", {31'd0, busy}, 32'd0);
        check_file("R10 state unchanged");

        for (int n = 0; n < 240; n++) begin
            if (n % 20 == 0)
                for (int b = 26; b < 32; b++)
                    set_reg(b, (b[0] && ($urandom % 4 != 0)) ? 8'h00 : 8'($urandom));
            access("R3 R4 R5 random", 2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom),
                   5'($urandom), ($urandom % 4 == 0), 5'($urandom), 8'($urandom), 0);
            if (n % 8 == 7) check_file("R2 R5 R6 random file");
        end
        check_file("R9 final file");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule